// File: doc/BRIEF.md
# I2C Slave Receiver with Sequenced Status Flags

This block is a receive-only I2C target. It watches open-drain SCL and SDA lines, detects START and STOP conditions, and compares the incoming address with a programmed own address. The address may be 7 bits or 10 bits wide. After a match it shifts in data bytes and acknowledges each one. Software services the block through a small register port. That port holds two status words, a control word, a data word and an own-address word.

The status flags are sticky. Each one clears only through a set order of register accesses. The block does not receive data until software has acknowledged the address match. It stretches the bus clock by holding SCL low while the address-match flag is pending. It also holds SCL low when a new byte arrives before the previous byte has been read. Software therefore never loses a byte and never has to meet bus timing.

Register selects (`reg_sel`) are as follows:
- 0: status word 0. Bit 0 is the address-matched flag, bit 1 is the byte-ready flag and bit 2 is the stop-seen flag.
- 1: status word 1, which reads as zero.
- 2: control word. Bit 0 enables the block and bit 1 selects 10-bit addressing.
- 3: received byte, in bits 7:0.
- 4: own address, in bits 9:0.

Reads take effect on a clock edge where `reg_rd` is high. Read data is valid combinationally from `reg_sel`.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, status word 0 and the control word read 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: In 7-bit mode with the block enabled, a START followed by the byte {own[6:0], 0} causes SDA to be held low during the ninth clock. It also sets status word 0 bit 0.
- R3: Status word 0 bit 0 clears only when status word 0 is read and status word 1 is read after it. A read of status word 1 alone leaves the bit set.
- R4: After an address acknowledge, SCL is held low for as long as status word 0 bit 0 stays set. SCL is released once that bit clears.
- R5: Each received data byte is acknowledged and sets status word 0 bit 1. The byte reads back from select 3, and that read clears bit 1.
- R6: If 8 further bits arrive while bit 1 is still set, the block holds SCL low before the ninth clock and gives no acknowledge. Once the pending byte is read, the new byte is loaded and acknowledged.
- R7: A STOP that ends a transfer addressed to this block sets status word 0 bit 2. The bit clears only when status word 0 is read and a control write follows. A control write alone leaves it set.
- R8: In 7-bit mode, an address byte that differs from {own[6:0], 0} in any bit, including a read request, gets no acknowledge and sets no flag. The data that follows is ignored until the next START.
- R9: In 10-bit mode, the header {11110, own[9:8], 0} is acknowledged without setting bit 0. A second byte equal to own[7:0] is acknowledged and sets bit 0.
- R10: In 10-bit mode, a wrong header or a wrong second byte gets no acknowledge and sets no flag.
- R11: A repeated START in the middle of a transfer restarts address matching without a STOP.
- R12: With control bit 0 clear, the block ignores the bus. It drives neither line and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| reg_sel | input | 3 | Register select |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data |

## Verification
The bench sweeps every single-bit corruption of the 7-bit address byte, including the direction bit. A design that compared too few bits would acknowledge a stranger's address, or would accept a read request.

It checks the ordered clearing sequences by first trying the wrong access alone. A flag that cleared on any single access would fail at that point. The overrun case stops a byte short of its ninth clock with the prior byte unread. A design that acknowledged early, or overwrote the buffer, would show up there.

The bench also covers several other cases:
- a repeated START carrying a mismatched address;
- rejected 10-bit headers and rejected low address bytes;
- a disabled block.

A design that kept matching state across a START, or listened while disabled, would acknowledge where it should not.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 10;
  localparam int REG_W  = ADDR_W;
  localparam int BYTE_W = 8;

  localparam logic [SEL_W-1:0] SEL_STAT0 = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STAT1 = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_OWN   = 3'd4;

  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HDR_ACK,
    ST_ADDR_LO,
    ST_ADR_ACK,
    ST_DATA,
    ST_FULL_WAIT,
    ST_DAT_ACK,
    ST_SKIP
  } srx_state_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_d;
  logic              sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_in;
          sda_chain[g] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain[g] <= 1'b1;
          sda_chain[g] <= 1'b1;
        end else begin
          scl_chain[g] <= scl_chain[g-1];
          sda_chain[g] <= sda_chain[g-1];
        end
      end
    end
  end

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
  import i2c_srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ten_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              am_flag,
  input  logic              rx_full,
  output logic              set_am,
  output logic              set_stop,
  output logic              push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_drive,
  output logic              scl_hold
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  srx_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              hit_q, hit_n;
  logic              byte_done;
  logic              shifting;
  logic [BYTE_W-1:0] hdr_exp;
  logic [BYTE_W-1:0] seven_exp;

  assign hdr_exp   = {TEN_BIT_PREFIX, own_addr[9:8], 1'b0};
  assign seven_exp = {own_addr[6:0], 1'b0};
  assign byte_done = scl_fall && (cnt_q == LAST_BIT);
  assign shifting  = (state_q == ST_ADDR) || (state_q == ST_ADDR_LO) ||
                     (state_q == ST_DATA);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    hit_n    = hit_q;
    set_am   = 1'b0;
    set_stop = 1'b0;
    push     = 1'b0;
    if (!en) begin
      state_n = ST_IDLE;
      hit_n   = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      hit_n   = 1'b0;
    end else if (stop_det) begin
      set_stop = hit_q;
      state_n  = ST_IDLE;
      hit_n    = 1'b0;
    end else begin
      if (shifting && scl_rise && (cnt_q != LAST_BIT)) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_n = cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_ADDR: if (byte_done) begin
          if (ten_bit) begin
            state_n = (sh_q == hdr_exp) ? ST_HDR_ACK : ST_SKIP;
          end else if (sh_q == seven_exp) begin
            state_n = ST_ADR_ACK;
            set_am  = 1'b1;
            hit_n   = 1'b1;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_HDR_ACK: if (scl_fall) begin
          state_n = ST_ADDR_LO;
          cnt_n   = '0;
        end
        ST_ADDR_LO: if (byte_done) begin
          if (sh_q == own_addr[7:0]) begin
            state_n = ST_ADR_ACK;
            set_am  = 1'b1;
            hit_n   = 1'b1;
          end else begin
            state_n = ST_SKIP;
          end
        end
        ST_ADR_ACK, ST_DAT_ACK: if (scl_fall) begin
          state_n = ST_DATA;
          cnt_n   = '0;
        end
        ST_DATA: if (byte_done) begin
          if (rx_full) begin
            state_n = ST_FULL_WAIT;
          end else begin
            push    = 1'b1;
            state_n = ST_DAT_ACK;
          end
        end
        ST_FULL_WAIT: if (!rx_full) begin
          push    = 1'b1;
          state_n = ST_DAT_ACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      hit_q   <= hit_n;
    end
  end

  assign rx_byte   = sh_q;
  assign sda_drive = (state_q == ST_HDR_ACK) || (state_q == ST_ADR_ACK) ||
                     (state_q == ST_DAT_ACK);
  assign scl_hold  = ((state_q == ST_DATA) && (cnt_q == '0) && am_flag) ||
                     (state_q == ST_FULL_WAIT);
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              set_am,
  input  logic              set_stop,
  input  logic              push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              en,
  output logic              ten_bit,
  output logic [ADDR_W-1:0] own_addr,
  output logic              am_flag,
  output logic              rx_full,
  output logic              stop_flag,
  output logic [REG_W-1:0]  rdata
);
  logic [1:0]        ctl_q, ctl_n;
  logic [ADDR_W-1:0] own_q, own_n;
  logic [BYTE_W-1:0] dat_q, dat_n;
  logic              am_q, am_n;
  logic              rxf_q, rxf_n;
  logic              stp_q, stp_n;
  logic              arm_am_q, arm_am_n;
  logic              arm_stp_q, arm_stp_n;
  logic              rd_s0, rd_s1, rd_dat, wr_ctl, wr_own;

  assign rd_s0  = rd && (sel == SEL_STAT0);
  assign rd_s1  = rd && (sel == SEL_STAT1);
  assign rd_dat = rd && (sel == SEL_DATA);
  assign wr_ctl = wr && (sel == SEL_CTRL);
  assign wr_own = wr && (sel == SEL_OWN);

  always_comb begin
    ctl_n     = wr_ctl ? wdata[1:0] : ctl_q;
    own_n     = wr_own ? wdata : own_q;
    dat_n     = push ? rx_byte : dat_q;
    rxf_n     = push ? 1'b1 : (rd_dat ? 1'b0 : rxf_q);

    am_n      = am_q;
    if (set_am)                 am_n = 1'b1;
    else if (rd_s1 && arm_am_q) am_n = 1'b0;
    arm_am_n  = arm_am_q;
    if (rd_s0)      arm_am_n = am_q;
    else if (rd_s1) arm_am_n = 1'b0;

    stp_n     = stp_q;
    if (set_stop)                   stp_n = 1'b1;
    else if (wr_ctl && arm_stp_q)   stp_n = 1'b0;
    arm_stp_n = arm_stp_q;
    if (rd_s0)       arm_stp_n = stp_q;
    else if (wr_ctl) arm_stp_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      own_q     <= '0;
      dat_q     <= '0;
      am_q      <= 1'b0;
      rxf_q     <= 1'b0;
      stp_q     <= 1'b0;
      arm_am_q  <= 1'b0;
      arm_stp_q <= 1'b0;
    end else begin
      ctl_q     <= ctl_n;
      own_q     <= own_n;
      dat_q     <= dat_n;
      am_q      <= am_n;
      rxf_q     <= rxf_n;
      stp_q     <= stp_n;
      arm_am_q  <= arm_am_n;
      arm_stp_q <= arm_stp_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_STAT0: rdata[2:0]        = {stp_q, rxf_q, am_q};
      SEL_CTRL:  rdata[1:0]        = ctl_q;
      SEL_DATA:  rdata[BYTE_W-1:0] = dat_q;
      SEL_OWN:   rdata             = own_q;
      default:   rdata             = '0;
    endcase
  end

  assign en        = ctl_q[0];
  assign ten_bit   = ctl_q[1];
  assign own_addr  = own_q;
  assign am_flag   = am_q;
  assign rx_full   = rxf_q;
  assign stop_flag = stp_q;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              en, ten_bit;
  logic [ADDR_W-1:0] own_addr;
  logic              am_flag, rx_full, stop_flag;
  logic              set_am, set_stop, push;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_srx_engine u_engine (
    .clk(clk), .rst_n(rst_int_n), .en(en), .ten_bit(ten_bit),
    .own_addr(own_addr), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .am_flag(am_flag), .rx_full(rx_full), .set_am(set_am),
    .set_stop(set_stop), .push(push), .rx_byte(rx_byte),
    .sda_drive(sda_oe), .scl_hold(scl_oe)
  );

  i2c_srx_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .sel(reg_sel), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .set_am(set_am), .set_stop(set_stop), .push(push),
    .rx_byte(rx_byte), .en(en), .ten_bit(ten_bit), .own_addr(own_addr),
    .am_flag(am_flag), .rx_full(rx_full), .stop_flag(stop_flag),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk
  import i2c_srx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] reg_sel,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             am_flag,
  input logic             rx_full,
  input logic             stop_flag,
  input logic             push,
  input logic             scl_oe,
  input logic             sda_oe
);
  a_r3_am_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(am_flag) |-> $past(reg_rd && (reg_sel == SEL_STAT1)));

  a_r7_stop_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> $past(reg_wr && (reg_sel == SEL_CTRL)));

  a_r5_push_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rx_full);

  a_r5_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_sel == SEL_DATA) && !push) |=> !rx_full);

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !rx_full);

  a_r4_ack_not_during_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !scl_oe);
endmodule

bind i2c_slave_rx i2c_srx_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .am_flag(am_flag), .rx_full(rx_full),
  .stop_flag(stop_flag), .push(push), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_oe, sda_oe;
  logic [2:0] reg_sel = 3'd0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  wire        scl_line = scl_m & ~scl_oe;
  wire        sda_line = sda_m & ~sda_oe;
  int         errs = 0, checks = 0;

  always #5 clk = ~clk;

  i2c_slave_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] s, output logic [9:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [9:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(Q);
    scl_high(); cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(Q);
    scl_high(); cyc(Q);
    sda_m = 1'b1; cyc(Q);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(Q);
      scl_high(); cyc(Q);
      scl_m = 1'b0; cyc(Q);
    end
  endtask

  task automatic ack_clk(output logic ack);
    sda_m = 1'b1; cyc(Q);
    scl_high(); cyc(Q/2);
    ack = ~sda_line; cyc(Q/2);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send8(b);
    ack_clk(ack);
  endtask

  task automatic clear_am();
    logic [9:0] v;
    rd(3'd0, v);
    rd(3'd1, v);
  endtask

  task automatic clear_stop();
    logic [9:0] v;
    rd(3'd0, v);
    wr(3'd2, 10'(reg_ctl));
  endtask

  logic [1:0] reg_ctl = 2'b01;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [9:0] v;
    logic       ack;
    logic [7:0] d;
    cyc(4);
    rst_n = 1'b1;
    cyc(5);

    // R1 reset state
    rd(3'd0, v); chk("R1 status0", v, 0);
    rd(3'd2, v); chk("R1 control", v, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);

    // R12 disabled block ignores the bus
    wr(3'd4, 10'h02A);
    bus_start(); send_byte(8'h54, ack);
    chk("R12 no ack while disabled", ack, 0);
    bus_stop();
    rd(3'd0, v); chk("R12 no flags while disabled", v, 0);

    wr(3'd2, 10'h001);
    // R8 every single-bit corruption of the 7-bit address byte
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(8'h54 ^ 8'(1 << k), ack);
      chk($sformatf("R8 no ack bit%0d", k), ack, 0);
      send_byte(8'h55, ack);
      chk($sformatf("R8 data ignored bit%0d", k), ack, 0);
      bus_stop();
      rd(3'd0, v); chk($sformatf("R8 no flags bit%0d", k), v, 0);
    end

    // R2 R3 R4 address match, stretching and ordered clearing
    bus_start(); send_byte(8'h54, ack);
    chk("R2 address ack", ack, 1);
    cyc(20);
    chk("R4 scl held while matched", scl_oe, 1);
    rd(3'd1, v); cyc(4);
    chk("R3 status1 alone keeps hold", scl_oe, 1);
    rd(3'd0, v); chk("R2 match flag", v[0], 1);
    rd(3'd1, v);
    rd(3'd0, v); chk("R3 match flag cleared", v[0], 0);
    cyc(6);
    chk("R4 scl released", scl_oe, 0);

    // R5 sweep over data values
    for (int i = 0; i < 32; i++) begin
      d = 8'((i * 37 + 11) & 255);
      send_byte(d, ack);
      chk("R5 data ack", ack, 1);
      rd(3'd0, v); chk("R5 ready set", v[1], 1);
      rd(3'd3, v); chk("R5 data value", v, d);
      rd(3'd0, v); chk("R5 ready cleared", v[1], 0);
    end

    // R6 overrun protection
    send_byte(8'hA5, ack);
    chk("R6 first ack", ack, 1);
    send8(8'h3C);
    cyc(20);
    chk("R6 scl held when full", scl_oe, 1);
    chk("R6 no early ack", sda_oe, 0);
    rd(3'd3, v); chk("R6 pending byte", v, 8'hA5);
    cyc(6);
    chk("R6 ack after read", sda_oe, 1);
    ack_clk(ack);
    chk("R6 ack seen", ack, 1);
    rd(3'd3, v); chk("R6 new byte", v, 8'h3C);

    // R7 stop flag and its clearing order
    bus_stop();
    cyc(6);
    wr(3'd2, 10'h001);
    rd(3'd0, v); chk("R7 stop flag survives lone write", v[2], 1);
    wr(3'd2, 10'h001);
    rd(3'd0, v); chk("R7 stop flag cleared", v[2], 0);

    // R11 repeated START restarts address matching
    bus_start(); send_byte(8'h54, ack);
    clear_am();
    send_byte(8'h11, ack);
    rd(3'd3, v); chk("R11 byte before restart", v, 8'h11);
    bus_start(); send_byte(8'h56, ack);
    chk("R11 mismatched after restart", ack, 0);
    send_byte(8'h22, ack);
    chk("R11 data ignored after restart", ack, 0);
    bus_start(); send_byte(8'h54, ack);
    chk("R11 match after restart", ack, 1);
    clear_am();
    bus_stop();
    cyc(6);
    clear_stop();

    // R9 10-bit addressing
    reg_ctl = 2'b11;
    wr(3'd4, 10'h2D6);
    wr(3'd2, 10'h003);
    bus_start(); send_byte(8'hF4, ack);
    chk("R9 header ack", ack, 1);
    rd(3'd0, v); chk("R9 no match after header", v[0], 0);
    send_byte(8'hD6, ack);
    chk("R9 low byte ack", ack, 1);
    rd(3'd0, v); chk("R9 match flag", v[0], 1);
    rd(3'd1, v);
    send_byte(8'h77, ack);
    chk("R9 data ack", ack, 1);
    rd(3'd3, v); chk("R9 data value", v, 8'h77);
    bus_stop();
    cyc(6);
    clear_stop();

    // R10 10-bit rejects
    bus_start(); send_byte(8'hF4, ack);
    send_byte(8'hD7, ack);
    chk("R10 wrong low byte", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hF2, ack);
    chk("R10 wrong header", ack, 0);
    bus_stop();
    rd(3'd0, v); chk("R10 no flags", v, 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule